// File: doc/BRIEF.md
# DLL Start-Up Sequencer

This block brings a PHY delay-locked loop back into lock after the card clock has been reprogrammed. The clock-programming logic gives it a one-cycle start pulse, a flag saying whether the frequency really changed, and the new rate in hertz. When the change is real and the new rate is above a threshold (52 MHz by default), the sequencer owns the DLL configuration word. It first quiesces the loop, then arms it with compensation, search mode, an initial count and a phase value, and then enables it. A settle interval follows each of these three writes. After that it polls the lock flag in the PHY status word at a fixed period until the flag is seen or a timeout runs out.

All intervals are counted in microsecond ticks that come from outside the block, so the same logic runs at any system clock rate. It also runs scaled down in simulation. The result is reported as a sticky `done_o` (lock seen) or `err_o` (lock failure), and `busy_o` covers the whole run.

Top module: `dll_bringup_seq`

## Requirements
- R1: A start pulse is accepted only when `clk_changed_i` is 1 and `clk_rate_i` is strictly greater than `RATE_MIN_HZ` (default 52,000,000) while the block is idle. Otherwise `busy_o` stays 0 and `dll_cfg_o`, `done_o` and `err_o` keep their values.
- R2: On the clock edge that accepts a start, bit 21 (loop enable) and bits 18, 24, 25, 26 and 27 (compensation enables) of `dll_cfg_o` are cleared.
- R3: `SETTLE_US` ticks after acceptance, the compensation bits (18, 24–27), bit 16 (search mode), bits 11 and 10 (initial count 0xC00) and bits 1:0 (phase value 3) are set.
- R4: `SETTLE_US` ticks after R3, bit 21 is set. Bit 21 never rises unless all compensation bits are already set.
- R5: After a further `SETTLE_US` ticks, the lock flag at bit 18 of `dll_sts_i` is sampled once, and again every `POLL_US` ticks. A lock that first appears between two sample points is acted on only at the next sample point. The other status bits have no effect.
- R6: A sample that sees lock ends the run: `done_o` goes to 1 and `busy_o` to 0. `done_o` holds until the next accepted start.
- R7: A sample that sees no lock, taken once at least `TIMEOUT_US` ticks have passed in the polling phase, ends the run with `err_o` = 1 and `busy_o` = 0. `err_o` holds until the next accepted start.
- R8: `busy_o` is 1 from the accepting edge until the run ends. It is never 1 together with `done_o` or `err_o`. A start pulse while busy is ignored and does not restart the timing.
- R9: Each step changes only its named bits, by read-modify-write. All other bits of `dll_cfg_o` keep their value, which after reset is `CFG_INIT`. Reset returns the block to idle with `dll_cfg_o` = `CFG_INIT`.
- R10: All intervals count pulses of `us_tick_i` only. A written value stays unchanged until the `SETTLE_US`-th tick after the previous step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request from the clock-programming logic |
| clk_changed_i | input | 1 | The card clock frequency was actually changed |
| clk_rate_i | input | 32 | New card clock rate in Hz |
| us_tick_i | input | 1 | One-cycle pulse per microsecond |
| dll_sts_i | input | 32 | PHY status word; bit 18 is lock |
| dll_cfg_o | output | 32 | DLL configuration word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run ended with lock seen |
| err_o | output | 1 | Last run ended in lock failure |

## Verification
The bench places lock just before, exactly on and just after sample points. A design that acts on lock as soon as it appears, or that misses the first sample taken right after the enable settle, finishes in a different number of ticks than expected. A lock that arrives exactly at the last sample before the timeout must give done, and one tick later must give an error; an off-by-one timeout comparator swaps these two outcomes. The bench also checks the configuration word after each step, including a second run on an already enabled loop, so a step that overwrites the word instead of modifying it shows up. A restart on a mid-run start pulse shows up as a longer run, and a rate of exactly 52 MHz must not start the sequence.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  timeunit 1ns; timeprecision 100ps;

  localparam int unsigned LOCK_BIT    = 18;
  localparam logic [31:0] EN_MASK     = 32'h0020_0000;  // bit 21
  localparam logic [31:0] COMP_MASK   = 32'h0F04_0000;  // bits 27:24, 18
  localparam logic [31:0] SEARCH_MASK = 32'h0001_0000;  // bit 16
  localparam logic [31:0] INIT_CNT    = 32'h0000_0C00;
  localparam logic [31:0] PHASE_VAL   = 32'h0000_0003;
  localparam logic [31:0] ARM_SET     = COMP_MASK | SEARCH_MASK | INIT_CNT | PHASE_VAL;
  localparam logic [31:0] NAMED_MASK  = ARM_SET | EN_MASK;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_QUIESCE,
    ST_ARM,
    ST_ENABLE,
    ST_POLL
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_QUIESCE,
    OP_ARM,
    OP_ENABLE
  } cfg_op_e;
endpackage

// File: rtl/dll_tick_timer.sv
module dll_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  timeunit 1ns; timeprecision 100ps;

  logic [W-1:0] cnt_q;

  assign expire_o = tick_i && !clr_i && (cnt_q == limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || expire_o)   cnt_q <= '0;
    else if (tick_i)              cnt_q <= cnt_q + W'(1);
  end

  // R10
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i != '0) |-> (cnt_q < limit_i));
endmodule

// File: rtl/dll_cfg_rmw.sv
module dll_cfg_rmw
  import dll_seq_pkg::*;
#(
  parameter logic [31:0] CFG_INIT = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  cfg_op_e     op_i,
  output logic [31:0] cfg_o
);
  timeunit 1ns; timeprecision 100ps;

  logic [31:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= CFG_INIT;
    end else begin
      unique case (op_i)
        OP_QUIESCE: cfg_q <= cfg_q & ~(EN_MASK | COMP_MASK);
        OP_ARM:     cfg_q <= cfg_q | ARM_SET;
        OP_ENABLE:  cfg_q <= cfg_q | EN_MASK;
        default:    cfg_q <= cfg_q;
      endcase
    end
  end

  assign cfg_o = cfg_q;

  // R9
  other_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cfg_q ^ $past(cfg_q)) & ~NAMED_MASK) == 32'h0);

  // R4
  enable_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cfg_q[21]) |-> ((cfg_q & COMP_MASK) == COMP_MASK));

  // R2
  quiesce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_QUIESCE) |=> ((cfg_q & (EN_MASK | COMP_MASK)) == 32'h0));
endmodule

// File: rtl/dll_seq_ctrl.sv
module dll_seq_ctrl
  import dll_seq_pkg::*;
#(
  parameter logic [31:0] RATE_MIN_HZ = 32'd52_000_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        clk_changed_i,
  input  logic [31:0] clk_rate_i,
  input  logic        lock_i,
  input  logic        wait_exp_i,
  input  logic        to_exp_i,
  output cfg_op_e     op_o,
  output logic        wait_clr_o,
  output logic        poll_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  timeunit 1ns; timeprecision 100ps;

  seq_state_e state_q, state_d;
  logic sample_q, to_hit_q, done_q, err_q;
  logic accept, finish_ok, finish_bad;

  assign accept     = (state_q == ST_IDLE) && start_i && clk_changed_i &&
                      (clk_rate_i > RATE_MIN_HZ);
  assign finish_ok  = (state_q == ST_POLL) && sample_q && lock_i;
  assign finish_bad = (state_q == ST_POLL) && sample_q && !lock_i && to_hit_q;

  always_comb begin
    state_d = state_q;
    op_o    = OP_HOLD;
    unique case (state_q)
      ST_IDLE:    if (accept)     begin state_d = ST_QUIESCE; op_o = OP_QUIESCE; end
      ST_QUIESCE: if (wait_exp_i) begin state_d = ST_ARM;     op_o = OP_ARM;     end
      ST_ARM:     if (wait_exp_i) begin state_d = ST_ENABLE;  op_o = OP_ENABLE;  end
      ST_ENABLE:  if (wait_exp_i) state_d = ST_POLL;
      ST_POLL:    if (finish_ok || finish_bad) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sample_q <= 1'b0;
      to_hit_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      // sample once on poll entry, then once per poll period
      sample_q <= ((state_q == ST_ENABLE) || (state_q == ST_POLL)) && wait_exp_i;
      if (accept)        to_hit_q <= 1'b0;
      else if (to_exp_i) to_hit_q <= 1'b1;
      if (accept) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (finish_ok) begin
        done_q <= 1'b1;
      end else if (finish_bad) begin
        err_q  <= 1'b1;
      end
    end
  end

  assign wait_clr_o = (state_q == ST_IDLE);
  assign poll_o     = (state_q == ST_POLL);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign err_o      = err_q;

  // R8
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!done_o && !err_o));

  // R6
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R8
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (state_q != ST_POLL) && start_i) |=> busy_o);

  // R6
  done_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(lock_i));

  // R7
  err_nolock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !$past(lock_i));

  // R1
  low_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && (clk_rate_i <= RATE_MIN_HZ)) |=> !busy_o);
endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
  import dll_seq_pkg::*;
#(
  parameter logic [31:0] RATE_MIN_HZ = 32'd52_000_000,
  parameter int          SETTLE_US   = 1000,
  parameter int          POLL_US     = 2000,
  parameter int          TIMEOUT_US  = 1_000_000,
  parameter logic [31:0] CFG_INIT    = 32'h0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        clk_changed_i,
  input  logic [31:0] clk_rate_i,
  input  logic        us_tick_i,
  input  logic [31:0] dll_sts_i,
  output logic [31:0] dll_cfg_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  timeunit 1ns; timeprecision 100ps;

  localparam int WAIT_MAX = (SETTLE_US > POLL_US) ? SETTLE_US : POLL_US;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
  localparam int TO_W     = $clog2(TIMEOUT_US + 1);

  cfg_op_e           op;
  logic              wait_clr, wait_exp, to_exp, poll_phase, lock;
  logic [WAIT_W-1:0] wait_lim;
  logic              sts_unused;

  assign lock       = dll_sts_i[LOCK_BIT];
  assign sts_unused = ^{dll_sts_i[31:LOCK_BIT+1], dll_sts_i[LOCK_BIT-1:0]};
  assign wait_lim   = poll_phase ? WAIT_W'(POLL_US) : WAIT_W'(SETTLE_US);

  dll_seq_ctrl #(
    .RATE_MIN_HZ (RATE_MIN_HZ)
  ) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .clk_changed_i (clk_changed_i),
    .clk_rate_i    (clk_rate_i),
    .lock_i        (lock),
    .wait_exp_i    (wait_exp),
    .to_exp_i      (to_exp),
    .op_o          (op),
    .wait_clr_o    (wait_clr),
    .poll_o        (poll_phase),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );

  // settle intervals, then poll period
  dll_tick_timer #(.W(WAIT_W)) u_wait_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (wait_clr),
    .tick_i   (us_tick_i),
    .limit_i  (wait_lim),
    .expire_o (wait_exp)
  );

  // lock-failure window, runs only while polling
  dll_tick_timer #(.W(TO_W)) u_to_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!poll_phase),
    .tick_i   (us_tick_i),
    .limit_i  (TO_W'(TIMEOUT_US)),
    .expire_o (to_exp)
  );

  dll_cfg_rmw #(.CFG_INIT(CFG_INIT)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .cfg_o  (dll_cfg_o)
  );
endmodule

// File: tb/dll_bringup_seq_tb.sv
module dll_bringup_seq_tb;
  timeunit 1ns; timeprecision 100ps;

  localparam int S = 4;
  localparam int P = 8;
  localparam int T = 40;
  localparam logic [31:0] INIT   = 32'h8130_5000;
  localparam logic [31:0] M_EN   = 32'h0020_0000;
  localparam logic [31:0] M_COMP = 32'h0F04_0000;
  localparam logic [31:0] M_ARM  = 32'h0F05_0C03;
  localparam logic [31:0] FINAL  = INIT | M_ARM | M_EN;
  localparam logic [31:0] ST_LOCK   = 32'h1234_0009;
  localparam logic [31:0] ST_NOLOCK = 32'hFFFB_FFFF;

  typedef struct packed {
    logic [31:0] rate;
    logic        chg;
    logic [15:0] lk;
    logic [1:0]  kind;   // 0 none, 1 done, 2 err
    logic [7:0]  ticks;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'd60_000_000,  1'b1, 16'd0,    2'd1, 8'd12},
    '{32'd60_000_000,  1'b1, 16'd4,    2'd1, 8'd12},
    '{32'd60_000_000,  1'b1, 16'd5,    2'd1, 8'd20},
    '{32'd100_000_000, 1'b1, 16'd12,   2'd1, 8'd20},
    '{32'd100_000_000, 1'b1, 16'd13,   2'd1, 8'd28},
    '{32'd200_000_000, 1'b1, 16'd44,   2'd1, 8'd52},
    '{32'd200_000_000, 1'b1, 16'd45,   2'd2, 8'd52},
    '{32'd60_000_000,  1'b1, 16'd9999, 2'd2, 8'd52},
    '{32'd52_000_000,  1'b1, 16'd0,    2'd0, 8'd0},
    '{32'd60_000_000,  1'b0, 16'd0,    2'd0, 8'd0},
    '{32'd52_000_001,  1'b1, 16'd0,    2'd1, 8'd12}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, chg = 1'b0, tick = 1'b0;
  logic [31:0] rate = 32'h0, sts = ST_NOLOCK;
  logic [31:0] dll_cfg_o;
  logic busy_o, done_o, err_o;

  int n_chk = 0, n_err = 0;
  int lock_delay = 0, en_ticks = 0, st_ticks = 0, last_ticks = 0, div = 0;
  bit en_prev = 1'b0, busy_prev = 1'b0, finished = 1'b0;

  always #2.5 clk = ~clk;

  dll_bringup_seq #(
    .SETTLE_US  (S),
    .POLL_US    (P),
    .TIMEOUT_US (T),
    .CFG_INIT   (INIT)
  ) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .start_i       (start),
    .clk_changed_i (chg),
    .clk_rate_i    (rate),
    .us_tick_i     (tick),
    .dll_sts_i     (sts),
    .dll_cfg_o     (dll_cfg_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o)
  );

  // tick source, lock model and tick bookkeeping, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (dll_cfg_o[21] && en_prev && tick) en_ticks++;
      else if (!dll_cfg_o[21])              en_ticks = 0;
      if (busy_prev && busy_o) begin
        if (tick) st_ticks++;
      end else if (busy_prev && !busy_o) begin
        last_ticks = st_ticks;
      end else if (!busy_prev) begin
        st_ticks = 0;
      end
      en_prev   = dll_cfg_o[21];
      busy_prev = busy_o;
      div  = (div == 2) ? 0 : div + 1;
      tick = (div == 0);
      sts  = (dll_cfg_o[21] && en_ticks >= lock_delay) ? ST_LOCK : ST_NOLOCK;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [31:0] r, input logic c);
    @(negedge clk); #1;
    start = 1'b1; rate = r; chg = c;
    @(negedge clk); #1;
    start = 1'b0;
    #1;
  endtask

  task automatic wait_st(input int n);
    int g = 0;
    while (st_ticks != n && g < 500) begin
      @(negedge clk); #2; g++;
    end
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy_o && g < 2000) begin
      @(negedge clk); #2; g++;
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v = VECS[i];
    logic [31:0] pre_cfg = dll_cfg_o;
    logic pre_done = done_o, pre_err = err_o;
    bit seen = 1'b0;
    lock_delay = int'(v.lk);
    pulse_start(v.rate, v.chg);
    if (v.kind == 2'd0) begin
      repeat (12) begin
        @(negedge clk); #2;
        if (busy_o) seen = 1'b1;
      end
      chk(!seen, $sformatf("R1 vec%0d start not accepted", i), seen, 0);
      chk(dll_cfg_o == pre_cfg, $sformatf("R1 vec%0d cfg kept", i), dll_cfg_o, pre_cfg);
      chk(done_o == pre_done && err_o == pre_err,
          $sformatf("R1 vec%0d flags kept", i), {done_o, err_o}, {pre_done, pre_err});
    end else begin
      chk(busy_o, $sformatf("R8 vec%0d busy after start", i), busy_o, 1);
      wait_idle();
      chk(done_o == (v.kind == 2'd1), $sformatf("R6 vec%0d done", i), done_o, v.kind == 2'd1);
      chk(err_o == (v.kind == 2'd2), $sformatf("R7 vec%0d error", i), err_o, v.kind == 2'd2);
      chk(last_ticks == int'(v.ticks), $sformatf("R5 vec%0d ticks to end", i),
          last_ticks, v.ticks);
      chk(dll_cfg_o == FINAL, $sformatf("R9 vec%0d final cfg", i), dll_cfg_o, FINAL);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;

    // reset state
    chk(dll_cfg_o == INIT, "R9 reset cfg", dll_cfg_o, INIT);
    chk(!busy_o, "R8 reset busy", busy_o, 0);
    chk(!done_o && !err_o, "R6 reset flags", {done_o, err_o}, 0);

    // step-by-step configuration word
    lock_delay = 0;
    pulse_start(32'd60_000_000, 1'b1);
    chk(dll_cfg_o == (INIT & ~(M_EN | M_COMP)), "R2 quiesce", dll_cfg_o, INIT & ~(M_EN | M_COMP));
    wait_st(S - 1);
    chk(dll_cfg_o == (INIT & ~(M_EN | M_COMP)), "R10 quiesce held", dll_cfg_o,
        INIT & ~(M_EN | M_COMP));
    wait_st(S);
    chk(dll_cfg_o == ((INIT & ~(M_EN | M_COMP)) | M_ARM), "R3 arm", dll_cfg_o,
        (INIT & ~(M_EN | M_COMP)) | M_ARM);
    wait_st(2 * S - 1);
    chk(!dll_cfg_o[21], "R10 arm held", dll_cfg_o[21], 0);
    wait_st(2 * S);
    chk(dll_cfg_o == FINAL, "R4 enable", dll_cfg_o, FINAL);
    chk(busy_o && !done_o, "R8 busy mid-run", {busy_o, done_o}, 2'b10);
    wait_idle();
    chk(done_o && last_ticks == 3 * S, "R5 first sample", last_ticks, 3 * S);

    // start while busy is ignored; second run on enabled loop
    lock_delay = 20;
    pulse_start(32'd80_000_000, 1'b1);
    chk(dll_cfg_o == (FINAL & ~(M_EN | M_COMP)), "R9 second quiesce", dll_cfg_o,
        FINAL & ~(M_EN | M_COMP));
    wait_st(6);
    pulse_start(32'd80_000_000, 1'b1);
    chk(busy_o, "R8 busy after ignored start", busy_o, 1);
    wait_idle();
    chk(done_o && last_ticks == 28, "R8 no restart", last_ticks, 28);

    // vector table
    for (int i = 0; i < NV; i++) run_vec(i);

    // reset in mid-run
    lock_delay = 0;
    pulse_start(32'd60_000_000, 1'b1);
    wait_st(5);
    @(negedge clk); #1 rst_n = 1'b0;
    #1;
    chk(!busy_o && dll_cfg_o == INIT, "R9 reset mid-run", dll_cfg_o, INIT);
    chk(!done_o && !err_o, "R6 reset clears flags", {done_o, err_o}, 0);
    @(negedge clk); #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule